// File: doc/BRIEF.md
# Cache Line Fill Word Sequencer

This block steers the words that main memory returns for a cache line read into their slots within the line. When a fill is launched it records the requested word address, the line length and two policy bits. It then produces the line offset for each word memory delivers, a write strobe for the cache data array, and a one-cycle completion pulse on the final word.

Two policy bits describe how the memory controller orders its burst. The first-word bit selects whether the burst begins at word zero or at the requested word. The order bit selects whether later words are reached by counting upward with wrap-around, or by XOR-ing the starting offset with a running index. Both bits are inputs, so one build can serve either kind of controller. With both bits low, the fill starts at the requested word and, because the order bit is low, follows the XOR order. The default controller instead combines a requested-word start with upward counting, which means the order bit high and the first-word bit low.

Top module: `line_fill_seq`

## Requirements
- R1: After synchronous reset the block is idle: `wr_en_o` and `line_done_o` stay low even if `mem_valid_i` is high.
- R2: `line_size_i` codes 0, 1, 2 and 3 select lines of 4, 8, 16 and 32 words. Exactly that many write strobes are issued per fill.
- R3: With `zero_first_i` = 1 the first word of a fill is written at offset 0.
- R4: With `zero_first_i` = 0 the first word is written at the requested offset, which is `req_word_i` modulo the line size.
- R5: With `seq_order_i` = 1 the k-th word (k from 0) is written at (first + k) modulo the line size.
- R6: With `seq_order_i` = 0 the k-th word is written at first XOR k.
- R7: The requested offset, line size and both policy bits are captured when a fill is accepted. Changes to those inputs during the fill have no effect on the offsets.
- R8: `wr_en_o` is high only on a cycle where `mem_valid_i` is high during a fill. On other fill cycles the offset holds its value and the fill does not advance.
- R9: `line_done_o` is a single-cycle pulse that coincides with the write strobe of the last word, and the block is idle afterwards.
- R10: A start strobe during a fill, including on the cycle of the last word, is ignored. It neither restarts the fill nor begins a new one.
- R11: While idle, `mem_valid_i` produces no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_start_i | input | 1 | Launches a fill when the block is idle |
| req_word_i | input | 5 | Word address requested by the miss |
| line_size_i | input | 2 | Line length code: 0=4, 1=8, 2=16, 3=32 words |
| zero_first_i | input | 1 | 1: burst starts at word 0; 0: burst starts at the requested word |
| seq_order_i | input | 1 | 1: upward order with wrap; 0: XOR order |
| mem_valid_i | input | 1 | Memory presents a data word this cycle |
| word_off_o | output | 5 | Line offset of the current word |
| wr_en_o | output | 1 | Cache data write strobe |
| line_done_o | output | 1 | Pulses with the last word of the line |

## Verification
The bench uses the default maximum line length of 32 words. This allows it to drive all four size codes through one build, so that both the wrap of upward counting and the XOR order are observed at every line length. Requested addresses above the selected line length show that the high bits are dropped. Fills with memory gaps, and fills where the configuration inputs change and start is raised mid-burst, show that the offsets follow only the captured settings.

// File: rtl/line_fill_pkg.sv
package line_fill_pkg;

    localparam int LF_MAX_WORDS = 32;
    localparam int LF_MIN_WORDS = 4;
    localparam int OFF_W        = $clog2(LF_MAX_WORDS);
    localparam int SEL_W        = $clog2($clog2(LF_MAX_WORDS) - $clog2(LF_MIN_WORDS) + 1);

    typedef logic [OFF_W-1:0] off_t;

    typedef struct packed {
        off_t mask;
        off_t first;
        logic seq;
    } fill_cfg_t;

    function automatic off_t size_mask(input logic [SEL_W-1:0] sel);
        int unsigned words;
        words = LF_MIN_WORDS << sel;
        return off_t'(words - 1);
    endfunction

    function automatic fill_cfg_t make_cfg(input logic [SEL_W-1:0] sel,
                                           input off_t req,
                                           input logic zero_first,
                                           input logic seq);
        fill_cfg_t c;
        c.mask  = size_mask(sel);
        c.first = zero_first ? '0 : (req & c.mask);
        c.seq   = seq;
        return c;
    endfunction

endpackage

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl
    import line_fill_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  fill_cfg_t cfg_in_i,
    input  logic      valid_i,
    output logic      busy_o,
    output off_t      cnt_o,
    output fill_cfg_t cfg_o,
    output logic      wr_en_o,
    output logic      done_o
);

    logic last_word;

    assign last_word = (cnt_o == cfg_o.mask);
    assign wr_en_o   = busy_o & valid_i;
    assign done_o    = wr_en_o & last_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            cnt_o  <= '0;
            cfg_o  <= '0;
        end else if (!busy_o) begin
            if (start_i) begin
                busy_o <= 1'b1;
                cnt_o  <= '0;
                cfg_o  <= cfg_in_i;
            end
        end else if (valid_i) begin
            cnt_o <= cnt_o + 1'b1;
            if (last_word) begin
                busy_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/line_fill_offset.sv
module line_fill_offset
    import line_fill_pkg::*;
(
    input  fill_cfg_t cfg_i,
    input  off_t      cnt_i,
    output off_t      off_o
);

    off_t wrap_off;
    off_t xor_off;

    assign wrap_off = (cfg_i.first + cnt_i) & cfg_i.mask;
    assign xor_off  = cfg_i.first ^ cnt_i;
    assign off_o    = cfg_i.seq ? wrap_off : xor_off;

endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq
    import line_fill_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_start_i,
    input  logic [OFF_W-1:0] req_word_i,
    input  logic [SEL_W-1:0] line_size_i,
    input  logic             zero_first_i,
    input  logic             seq_order_i,
    input  logic             mem_valid_i,
    output logic [OFF_W-1:0] word_off_o,
    output logic             wr_en_o,
    output logic             line_done_o
);

    fill_cfg_t cfg_next;
    fill_cfg_t cfg_q;
    off_t      cnt;
    logic      busy;

    assign cfg_next = make_cfg(line_size_i, req_word_i, zero_first_i, seq_order_i);

    line_fill_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (fill_start_i),
        .cfg_in_i (cfg_next),
        .valid_i  (mem_valid_i),
        .busy_o   (busy),
        .cnt_o    (cnt),
        .cfg_o    (cfg_q),
        .wr_en_o  (wr_en_o),
        .done_o   (line_done_o)
    );

    line_fill_offset u_off (
        .cfg_i (cfg_q),
        .cnt_i (cnt),
        .off_o (word_off_o)
    );

endmodule

// File: rtl/line_fill_seq_chk.sv
module line_fill_seq_chk
    import line_fill_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      fill_start_i,
    input logic      zero_first_i,
    input logic      mem_valid_i,
    input off_t      word_off_o,
    input logic      wr_en_o,
    input logic      line_done_o,
    input logic      busy,
    input off_t      cnt,
    input fill_cfg_t cfg_q
);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!wr_en_o && !line_done_o));

    assert_write_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
        !mem_valid_i |-> !wr_en_o);

    assert_offset_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_en_o) |=> $stable(word_off_o));

    assert_done_with_write_R9: assert property (@(posedge clk) disable iff (rst)
        line_done_o |-> wr_en_o);

    assert_done_ends_fill_R9: assert property (@(posedge clk) disable iff (rst)
        line_done_o |=> !busy);

    assert_cfg_held_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !line_done_o) |=> $stable(cfg_q));

    assert_zero_start_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && $past(zero_first_i)) |-> (word_off_o == '0));

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && fill_start_i && !wr_en_o) |=> $stable(cnt));

endmodule

bind line_fill_seq line_fill_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .fill_start_i (fill_start_i),
    .zero_first_i (zero_first_i),
    .mem_valid_i  (mem_valid_i),
    .word_off_o   (word_off_o),
    .wr_en_o      (wr_en_o),
    .line_done_o  (line_done_o),
    .busy         (busy),
    .cnt          (cnt),
    .cfg_q        (cfg_q)
);

// File: tb/line_fill_seq_tb.sv
module line_fill_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 10;

    // fields: size[10:9] req[8:4] zero_first[3] seq[2] disturb[1] gaps[0]
    localparam logic [10:0] VEC [NVEC] = '{
        {2'd0, 5'd2,  1'b0, 1'b1, 1'b0, 1'b0},
        {2'd0, 5'd3,  1'b0, 1'b0, 1'b0, 1'b0},
        {2'd1, 5'd13, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'd1, 5'd6,  1'b0, 1'b0, 1'b1, 1'b0},
        {2'd2, 5'd9,  1'b1, 1'b1, 1'b0, 1'b0},
        {2'd2, 5'd11, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd3, 5'd27, 1'b0, 1'b1, 1'b1, 1'b1},
        {2'd3, 5'd19, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd3, 5'd5,  1'b1, 1'b0, 1'b0, 1'b0},
        {2'd0, 5'd31, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fill_start_i = 1'b0;
    logic [4:0] req_word_i = '0;
    logic [1:0] line_size_i = '0;
    logic       zero_first_i = 1'b0;
    logic       seq_order_i = 1'b1;
    logic       mem_valid_i = 1'b0;
    logic [4:0] word_off_o;
    logic       wr_en_o;
    logic       line_done_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_fill_seq u_dut (
        .clk          (clk),
        .rst          (rst),
        .fill_start_i (fill_start_i),
        .req_word_i   (req_word_i),
        .line_size_i  (line_size_i),
        .zero_first_i (zero_first_i),
        .seq_order_i  (seq_order_i),
        .mem_valid_i  (mem_valid_i),
        .word_off_o   (word_off_o),
        .wr_en_o      (wr_en_o),
        .line_done_o  (line_done_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_off(input int first, input int k, input int n, input bit seq);
        return seq ? ((first + k) % n) : (first ^ k);
    endfunction

    task automatic run_fill(input logic [10:0] v);
        int  n;
        int  first;
        bit  seq;
        n     = 4 << v[10:9];
        first = v[3] ? 0 : (int'(v[8:4]) % n);
        seq   = v[2];
        @(negedge clk);
        line_size_i  = v[10:9];
        req_word_i   = v[8:4];
        zero_first_i = v[3];
        seq_order_i  = v[2];
        fill_start_i = 1'b1;
        mem_valid_i  = 1'b0;
        @(negedge clk);
        fill_start_i = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (v[0] && (k % 3 == 1)) begin
                mem_valid_i = 1'b0;
                #1;
                chk("R8 no strobe in gap", int'(wr_en_o), 0);
                chk("R8 offset held in gap", int'(word_off_o), exp_off(first, k, n, seq));
                @(negedge clk);
            end
            if (v[1] && k == 1) begin
                fill_start_i = 1'b1;
                zero_first_i = ~v[3];
                seq_order_i  = ~v[2];
                req_word_i   = ~v[8:4];
                line_size_i  = ~v[10:9];
            end
            mem_valid_i = 1'b1;
            #1;
            if (k == 0)
                chk(v[3] ? "R3 first offset" : "R4 first offset", int'(word_off_o), first);
            else if (v[1])
                chk("R7 offset after config change", int'(word_off_o), exp_off(first, k, n, seq));
            else
                chk(seq ? "R5 wrap offset" : "R6 xor offset", int'(word_off_o), exp_off(first, k, n, seq));
            chk("R8 strobe on valid", int'(wr_en_o), 1);
            chk("R2 R9 done on last word", int'(line_done_o), (k == n - 1) ? 1 : 0);
            @(negedge clk);
            fill_start_i = 1'b0;
            mem_valid_i  = 1'b0;
        end
        mem_valid_i = 1'b1;
        #1;
        chk("R11 idle after fill", int'(wr_en_o), 0);
        chk("R10 no fill begun by ignored start", int'(line_done_o), 0);
        @(negedge clk);
        mem_valid_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!ended) begin
            ended = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        mem_valid_i = 1'b1;
        #1;
        chk("R1 reset strobe", int'(wr_en_o), 0);
        chk("R1 reset done", int'(line_done_o), 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R1 idle after reset", int'(wr_en_o), 0);
        mem_valid_i = 1'b0;

        foreach (VEC[i]) run_fill(VEC[i]);

        // start raised together with the last word: must not begin a new fill (R10)
        @(negedge clk);
        line_size_i = 2'd0; req_word_i = 5'd1; zero_first_i = 1'b0; seq_order_i = 1'b1;
        fill_start_i = 1'b1;
        @(negedge clk);
        fill_start_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            mem_valid_i  = 1'b1;
            fill_start_i = (k == 3);
            @(negedge clk);
        end
        fill_start_i = 1'b0;
        mem_valid_i  = 1'b1;
        #1;
        chk("R10 start on last word ignored", int'(wr_en_o), 0);
        @(negedge clk);
        mem_valid_i = 1'b0;

        // reset in the middle of a fill returns to idle (R1)
        fill_start_i = 1'b1;
        @(negedge clk);
        fill_start_i = 1'b0;
        mem_valid_i  = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset aborts fill", int'(wr_en_o), 0);
        @(negedge clk);
        mem_valid_i = 1'b0;

        // full 32-word line in wrap order from word 30 (R2, R5)
        run_fill({2'd3, 5'd30, 1'b0, 1'b1, 1'b0, 1'b0});

        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule